// File: doc/BRIEF.md
# Coded Dual-Tone Signalling Generator

This block produces a stream of signed digital samples carrying a dual-tone (DTMF) signal for a transmit voice path. A 4-bit pair code picks one low-group and one high-group frequency. Each frequency has its own phase accumulator, and both accumulators read a shared sine table. The two tone values are added together, then scaled by a level setting, then saturated to the output width.

Two options change the pair that is emitted. A twist option lowers the low-group tone by about 2 dB before the sum. A single-tone option keeps only one member of the pair.

The host drives a sample strobe at the system sample rate, which is 8 kHz by default. Each strobe moves both accumulators forward by one step and produces one output sample. The host sets the enable low while no tone should be sent. With the enable low, the phases return to zero and the output stays at zero.

Top module: `dtmf_tone_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `sample_o` is 0 and `sample_vld_o` is 0.
- R2: Codes 1 to 9 select (low, high) Hz as follows. Code 1 is (697,1209), 2 is (697,1336), 3 is (697,1477). Code 4 is (770,1209), 5 is (770,1336), 6 is (770,1477). Code 7 is (852,1209), 8 is (852,1336), 9 is (852,1477).
- R3: Code 10 selects (941,1336), code 11 selects (941,1209) and code 12 selects (941,1477).
- R4: Codes 13, 14, 15 and 0 select low tones of 697, 770, 852 and 941 Hz respectively, each paired with 1633 Hz.
- R5: Each tone has a 24-bit phase that starts at 0. On every strobe taken while enabled, the phase moves forward, modulo 2^24, by round(f·2^24/8000). Between strobes the phase holds. The tone value is round(16383·sin(2π·k/256)), where k is the top 8 phase bits.
- R6: When `twist_i` is set at the strobe, the low-group value is replaced by floor(value·26029/2^15) before the sum.
- R7: When `single_i` is set at the strobe, codes 1 to 12 emit only the low-group tone, and codes 13, 14, 15 and 0 emit only the 1633 Hz tone. The other tone contributes 0.
- R8: The output sample is floor((low + high)·L/128), where L is the unsigned `level_i` sampled at the strobe.
- R9: A scaled result outside the signed 16-bit range is clamped to 32767 or to -32768. It never wraps.
- R10: While `en_i` is low, both phases are reset to 0. On the next cycle `sample_o` is 0 and `sample_vld_o` is 0.
- R11: A strobe on a clock edge with `en_i` high yields `sample_vld_o` high for one cycle after the third edge, provided `en_i` stays high through that edge. The new `sample_o` appears with it and holds until the next sample. Code, mode and level are sampled only at strobe edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Tone generation enable |
| smp_en_i | input | 1 | Sample strobe, one cycle per output sample |
| code_i | input | 4 | Tone-pair code |
| single_i | input | 1 | Emit only one tone of the pair |
| twist_i | input | 1 | Attenuate the low-group tone by about 2 dB |
| level_i | input | 8 | Output level, 128 is unity |
| sample_o | output | 16 | Signed output sample |
| sample_vld_o | output | 1 | One-cycle pulse when a new sample is present |

## Verification
Some behaviour is checked on every cycle. These checks cover the timing of the valid pulse against the strobe and enable history, the clearing of both phases and the output while disabled, and the phases holding between strobes and moving on each enabled strobe. The numeric content of the samples can only be shown by comparing the full output stream against the bench's reference model under chosen stimuli. That content includes the code-to-frequency mapping, the twist gain, the choice of tone in single-tone mode, level scaling and clamping at both rails. Code changes that arrive between strobes are covered the same way.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

  typedef struct packed {
    logic single;
    logic twist;
    logic hi_only;
  } dtmf_mode_t;

  // Low-group frequency in Hz for a pair code
  function automatic int lo_hz(input logic [3:0] code);
    case (code)
      4'd1, 4'd2, 4'd3, 4'd13:   return 697;
      4'd4, 4'd5, 4'd6, 4'd14:   return 770;
      4'd7, 4'd8, 4'd9, 4'd15:   return 852;
      default:                   return 941;
    endcase
  endfunction

  // High-group frequency in Hz for a pair code
  function automatic int hi_hz(input logic [3:0] code);
    case (code)
      4'd1, 4'd4, 4'd7, 4'd11:   return 1209;
      4'd2, 4'd5, 4'd8, 4'd10:   return 1336;
      4'd3, 4'd6, 4'd9, 4'd12:   return 1477;
      default:                   return 1633;
    endcase
  endfunction

  // Codes whose single-tone member is the high-group tone
  function automatic logic hi_only(input logic [3:0] code);
    return (code == 4'd0) || (code >= 4'd13);
  endfunction

endpackage

// File: rtl/dtmf_tune_rom.sv
module dtmf_tune_rom #(
  parameter int PHASE_W = 24,
  parameter int FS_HZ   = 8000
) (
  input  logic [3:0]         code,
  output logic [PHASE_W-1:0] tw_lo,
  output logic [PHASE_W-1:0] tw_hi
);
  import dtmf_pkg::*;

  localparam int NCODE = 16;
  localparam real SCALE = (2.0 ** PHASE_W) / real'(FS_HZ);

  logic [PHASE_W-1:0] lo_tab [NCODE];
  logic [PHASE_W-1:0] hi_tab [NCODE];

  initial begin
    for (int i = 0; i < NCODE; i++) begin
      lo_tab[i] = PHASE_W'($rtoi(real'(lo_hz(4'(i))) * SCALE + 0.5));
      hi_tab[i] = PHASE_W'($rtoi(real'(hi_hz(4'(i))) * SCALE + 0.5));
    end
  end

  assign tw_lo = lo_tab[code];
  assign tw_hi = hi_tab[code];
endmodule

// File: rtl/dtmf_sine_rom.sv
module dtmf_sine_rom #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic [ADDR_W-1:0]        addr_a,
  input  logic [ADDR_W-1:0]        addr_b,
  output logic signed [DATA_W-1:0] data_a,
  output logic signed [DATA_W-1:0] data_b
);
  localparam int  DEPTH = 2 ** ADDR_W;
  localparam real AMP   = real'(2 ** (DATA_W - 2) - 1);
  localparam real PI    = 3.14159265358979323846;

  logic signed [DATA_W-1:0] rom [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      real v;
      v = AMP * $sin(2.0 * PI * real'(i) / real'(DEPTH));
      if (v >= 0.0) rom[i] = DATA_W'($rtoi(v + 0.5));
      else          rom[i] = DATA_W'(-$rtoi(-v + 0.5));
    end
  end

  always_ff @(posedge clk) begin
    data_a <= rom[addr_a];
    data_b <= rom[addr_b];
  end
endmodule

// File: rtl/dtmf_mix.sv
module dtmf_mix #(
  parameter int OUT_W     = 16,
  parameter int LVL_W     = 8,
  parameter int LVL_SHIFT = 7
) (
  input  logic signed [OUT_W-1:0] sin_lo,
  input  logic signed [OUT_W-1:0] sin_hi,
  input  dtmf_pkg::dtmf_mode_t    mode,
  input  logic [LVL_W-1:0]        level,
  output logic signed [OUT_W-1:0] mixed
);
  localparam int TW_W   = 2 * OUT_W;
  localparam int SUM_W  = OUT_W + 2;
  localparam int PROD_W = SUM_W + LVL_W + 1;
  localparam logic signed [OUT_W-1:0]  TWIST_K = OUT_W'(26029);
  localparam logic signed [PROD_W-1:0] SAT_HI  = PROD_W'(2 ** (OUT_W - 1) - 1);
  localparam logic signed [PROD_W-1:0] SAT_LO  = -SAT_HI - PROD_W'(1);

  logic signed [OUT_W-1:0]  lo_sel, hi_sel, lo_adj;
  logic signed [TW_W-1:0]   tw_prod;
  logic signed [SUM_W-1:0]  sum;
  logic signed [PROD_W-1:0] scaled, shifted;

  always_comb begin
    lo_sel  = (mode.single && mode.hi_only)  ? '0 : sin_lo;
    hi_sel  = (mode.single && !mode.hi_only) ? '0 : sin_hi;
    tw_prod = TW_W'(lo_sel) * TW_W'(TWIST_K);
    lo_adj  = mode.twist ? OUT_W'(tw_prod >>> 15) : lo_sel;
    sum     = SUM_W'(lo_adj) + SUM_W'(hi_sel);
    scaled  = PROD_W'(sum) * PROD_W'($signed({1'b0, level}));
    shifted = scaled >>> LVL_SHIFT;
    if (shifted > SAT_HI)      mixed = OUT_W'(SAT_HI);
    else if (shifted < SAT_LO) mixed = OUT_W'(SAT_LO);
    else                       mixed = OUT_W'(shifted);
  end
endmodule

// File: rtl/dtmf_tone_gen.sv
module dtmf_tone_gen #(
  parameter int PHASE_W   = 24,
  parameter int FS_HZ     = 8000,
  parameter int LUT_AW    = 8,
  parameter int OUT_W     = 16,
  parameter int LVL_W     = 8,
  parameter int LVL_SHIFT = 7
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en_i,
  input  logic                    smp_en_i,
  input  logic [3:0]              code_i,
  input  logic                    single_i,
  input  logic                    twist_i,
  input  logic [LVL_W-1:0]        level_i,
  output logic signed [OUT_W-1:0] sample_o,
  output logic                    sample_vld_o
);
  import dtmf_pkg::*;

  localparam int NGRP = 2;

  logic [PHASE_W-1:0]      tw   [NGRP];
  logic [PHASE_W-1:0]      acc  [NGRP];
  logic [PHASE_W-1:0]      acc_lo, acc_hi;
  logic signed [OUT_W-1:0] sin_lo, sin_hi, mixed;
  logic                    s1, s2;
  dtmf_mode_t              mode1, mode2;
  logic [LVL_W-1:0]        lvl1, lvl2;

  dtmf_tune_rom #(.PHASE_W(PHASE_W), .FS_HZ(FS_HZ)) u_tune (
    .code (code_i),
    .tw_lo(tw[0]),
    .tw_hi(tw[1])
  );

  // One phase accumulator per tone group
  for (genvar g = 0; g < NGRP; g++) begin : g_acc
    always_ff @(posedge clk) begin
      if (rst || !en_i)  acc[g] <= '0;
      else if (smp_en_i) acc[g] <= acc[g] + tw[g];
    end
  end

  assign acc_lo = acc[0];
  assign acc_hi = acc[1];

  dtmf_sine_rom #(.ADDR_W(LUT_AW), .DATA_W(OUT_W)) u_sine (
    .clk   (clk),
    .addr_a(acc_lo[PHASE_W-1 -: LUT_AW]),
    .addr_b(acc_hi[PHASE_W-1 -: LUT_AW]),
    .data_a(sin_lo),
    .data_b(sin_hi)
  );

  // Strobe and control follow the data through the table stage
  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= smp_en_i;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode1 <= '0;
      mode2 <= '0;
      lvl1  <= '0;
      lvl2  <= '0;
    end else begin
      if (smp_en_i) begin
        mode1 <= '{single: single_i, twist: twist_i, hi_only: hi_only(code_i)};
        lvl1  <= level_i;
      end
      mode2 <= mode1;
      lvl2  <= lvl1;
    end
  end

  dtmf_mix #(.OUT_W(OUT_W), .LVL_W(LVL_W), .LVL_SHIFT(LVL_SHIFT)) u_mix (
    .sin_lo(sin_lo),
    .sin_hi(sin_hi),
    .mode  (mode2),
    .level (lvl2),
    .mixed (mixed)
  );

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      sample_o     <= '0;
      sample_vld_o <= 1'b0;
    end else begin
      sample_vld_o <= s2;
      if (s2) sample_o <= mixed;
    end
  end
endmodule

// File: rtl/dtmf_tone_gen_chk.sv
module dtmf_tone_gen_chk #(
  parameter int PHASE_W = 24,
  parameter int OUT_W   = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    en_i,
  input logic                    smp_en_i,
  input logic signed [OUT_W-1:0] sample_o,
  input logic                    sample_vld_o,
  input logic [PHASE_W-1:0]      acc_lo,
  input logic [PHASE_W-1:0]      acc_hi
);
  // R11: valid pulse exactly three edges after an enabled strobe
  a_r11_vld_timing: assert property (@(posedge clk) disable iff (rst)
    sample_vld_o == ($past(smp_en_i && en_i && !rst, 3) &&
                     $past(en_i && !rst, 2) && $past(en_i && !rst, 1)));

  // R10: disabled means zero output and no valid on the next cycle
  a_r10_disabled_zero: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (sample_o == '0) && !sample_vld_o);

  // R10: disabled clears both phases
  a_r10_phase_clear: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (acc_lo == '0) && (acc_hi == '0));

  // R5: phases hold between strobes
  a_r5_phase_hold: assert property (@(posedge clk) disable iff (rst)
    (en_i && !smp_en_i) |=> $stable(acc_lo) && $stable(acc_hi));

  // R5: phases move on every enabled strobe
  a_r5_phase_step: assert property (@(posedge clk) disable iff (rst)
    (en_i && smp_en_i) |=> (acc_lo != $past(acc_lo)) && (acc_hi != $past(acc_hi)));

  // R9: a presented sample is always a known value
  a_r9_known_sample: assert property (@(posedge clk) disable iff (rst)
    sample_vld_o |-> !$isunknown(sample_o));
endmodule

bind dtmf_tone_gen dtmf_tone_gen_chk #(.PHASE_W(PHASE_W), .OUT_W(OUT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .en_i        (en_i),
  .smp_en_i    (smp_en_i),
  .sample_o    (sample_o),
  .sample_vld_o(sample_vld_o),
  .acc_lo      (acc_lo),
  .acc_hi      (acc_hi)
);

// File: tb/dtmf_tone_gen_test.sv
`timescale 1ns/1ps
module dtmf_tone_gen_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst = 1'b1, en = 1'b0, smp_en = 1'b0;
  logic [3:0]        code = 4'd1;
  logic              single = 1'b0, twist = 1'b0;
  logic [7:0]        level = 8'd128;
  logic signed [15:0] sample;
  logic              vld;

  dtmf_tone_gen uut (
    .clk(clk), .rst(rst), .en_i(en), .smp_en_i(smp_en), .code_i(code),
    .single_i(single), .twist_i(twist), .level_i(level),
    .sample_o(sample), .sample_vld_o(vld)
  );

  int vectors = 0, errors = 0;
  string req = "R1";
  bit checking = 0, run = 0;
  int max_seen = 0, min_seen = 0;

  // Keypad pair table indexed by code (R2, R3, R4)
  int lo_f [16] = '{941, 697, 697, 697, 770, 770, 770, 852,
                    852, 852, 941, 941, 941, 697, 770, 852};
  int hi_f [16] = '{1633, 1209, 1336, 1477, 1209, 1336, 1477, 1209,
                    1336, 1477, 1336, 1209, 1477, 1633, 1633, 1633};

  function automatic longint tune(int f);
    return longint'($rtoi(real'(f) * 16777216.0 / 8000.0 + 0.5));
  endfunction

  function automatic int sine_at(int k);
    real v;
    v = 16383.0 * $sin(2.0 * 3.14159265358979323846 * real'(k) / 256.0);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(-v + 0.5);
  endfunction

  function automatic int mix(int sl, int sh, bit sgl, bit tws, bit hio, int lvl);
    int lo = sl, hi = sh;
    longint p;
    if (sgl && hio)  lo = 0;
    if (sgl && !hio) hi = 0;
    if (tws) lo = (lo * 26029) >>> 15;
    p = longint'(lo + hi) * lvl;
    p = p >>> 7;
    if (p > 32767)  p = 32767;
    if (p < -32768) p = -32768;
    return int'(p);
  endfunction

  // Behavioural reference model, advanced on each edge
  longint m_acc_lo, m_acc_hi;
  int m_sl, m_sh, m_out, m_lvl1, m_lvl2;
  bit m_vld, m_p1, m_p2;
  bit m_sg1, m_tw1, m_ho1, m_sg2, m_tw2, m_ho2;

  always @(posedge clk) begin
    if (rst) begin
      m_acc_lo = 0; m_acc_hi = 0; m_out = 0; m_vld = 0; m_p1 = 0; m_p2 = 0;
      m_sg1 = 0; m_tw1 = 0; m_ho1 = 0; m_sg2 = 0; m_tw2 = 0; m_ho2 = 0;
      m_lvl1 = 0; m_lvl2 = 0;
    end else begin
      int nsl, nsh;
      nsl = sine_at(int'(m_acc_lo >> 16));
      nsh = sine_at(int'(m_acc_hi >> 16));
      if (!en) begin
        m_out = 0; m_vld = 0; m_p1 = 0; m_p2 = 0; m_acc_lo = 0; m_acc_hi = 0;
      end else begin
        m_vld = m_p2;
        if (m_p2) m_out = mix(m_sl, m_sh, m_sg2, m_tw2, m_ho2, m_lvl2);
        m_p2 = m_p1;
        m_p1 = smp_en;
        if (smp_en) begin
          m_acc_lo = (m_acc_lo + tune(lo_f[code])) & 64'hFFFFFF;
          m_acc_hi = (m_acc_hi + tune(hi_f[code])) & 64'hFFFFFF;
        end
      end
      m_sg2 = m_sg1; m_tw2 = m_tw1; m_ho2 = m_ho1; m_lvl2 = m_lvl1;
      if (smp_en) begin
        m_sg1 = single; m_tw1 = twist; m_ho1 = (code == 0) || (code >= 13);
        m_lvl1 = int'(level);
      end
      m_sl = nsl; m_sh = nsh;
    end
  end

  // Strobe every fifth cycle
  int scnt = 0;
  always @(negedge clk) begin
    scnt = (scnt + 1) % 5;
    smp_en = run && (scnt == 0);
  end

  // Per-cycle comparison: the sample stream carries R5 (phase and table) for every scenario
  always @(negedge clk) begin
    if (checking) begin
      vectors++;
      if (sample !== 16'(m_out) || vld !== m_vld) begin
        errors++;
        $display("FAIL %s/R5: sample=%0d vld=%0b expected sample=%0d vld=%0b",
                 req, sample, vld, m_out, m_vld);
      end
      if (req == "R9" && vld) begin
        if (int'(sample) > max_seen) max_seen = int'(sample);
        if (int'(sample) < min_seen) min_seen = int'(sample);
      end
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
  endtask

  initial begin
    cycles(4);
    // R1: reset state
    vectors++;
    if (sample !== 16'sd0 || vld !== 1'b0) begin
      errors++;
      $display("FAIL R1: sample=%0d vld=%0b expected sample=0 vld=0", sample, vld);
    end
    rst = 1'b0;
    cycles(1);
    vectors++;
    if (sample !== 16'sd0 || vld !== 1'b0) begin
      errors++;
      $display("FAIL R1: after release sample=%0d vld=%0b expected 0 0", sample, vld);
    end
    checking = 1;
    en = 1'b1; run = 1;

    req = "R2";
    for (int c = 1; c <= 9; c++) begin code = 4'(c); cycles(40); end
    req = "R3";
    for (int c = 10; c <= 12; c++) begin code = 4'(c); cycles(40); end
    req = "R4";
    for (int c = 13; c <= 16; c++) begin code = 4'(c % 16); cycles(40); end

    req = "R6";
    twist = 1'b1; code = 4'd5; cycles(40);
    code = 4'd0; cycles(40);
    twist = 1'b0;

    req = "R7";
    single = 1'b1; code = 4'd5;  cycles(40);
    code = 4'd14; cycles(40);
    twist = 1'b1; code = 4'd3; cycles(40);
    twist = 1'b0; single = 1'b0;

    req = "R11";
    for (int k = 0; k < 12; k++) begin code = 4'((k * 7) % 16); cycles(3); end
    for (int k = 0; k < 6; k++) begin level = 8'(100 + k * 20); cycles(2); end

    req = "R8";
    level = 8'd64;  code = 4'd8; cycles(40);
    level = 8'd0;   cycles(30);
    level = 8'd200; code = 4'd11; cycles(40);

    req = "R9";
    level = 8'd255; code = 4'd12; cycles(400);

    req = "R10";
    en = 1'b0; cycles(12);
    en = 1'b1; code = 4'd6; level = 8'd128; cycles(23);
    en = 1'b0; cycles(1);
    en = 1'b1; cycles(30);
    en = 1'b0; cycles(8);

    checking = 0;
    // R9: the stream clamped at both rails without wrapping
    vectors++;
    if (max_seen != 32767 || min_seen != -32768) begin
      errors++;
      $display("FAIL R9: extremes max=%0d min=%0d expected max=32767 min=-32768",
               max_seen, min_seen);
    end
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    summary();
    $finish;
  end
endmodule